// File: doc/BRIEF.md
# Multicast Ring Cell Switch

This block moves 16-bit cells between four ingress ports and four egress ports. A small queue sits at each ingress and each egress. Between the queues is a loop of four register stages, one per port. The loop advances on every clock, so cells travel through it in a pipeline. Each cell names its targets with a per-egress bitmask. While a cell circulates, each stage it passes removes the bit of its own port as it hands a copy to that port's egress queue. One cell can therefore reach several egress ports.

Contention for an egress port is settled by where a cell sits on the loop. If the egress queue is full, the cell keeps its bit and comes back on a later lap. A stage that has no pending bits is free, and the ingress queue of that port may place its head cell there. Three counters report how many cells the ingress queues took in, how many copies were handed out at the egress ports, and how many cells were discarded.

Top module: `ring_switch`

## Requirements
- R1: A cell has the dest mask in bits [15:12], where bit 12+k names egress k. It has the source id in bits [11:8] and the payload in bits [7:0]. An ingress queue stores an arriving cell when its in_valid bit is high and the queue is not full.
- R2: Every cell handed out on out_cell[k] carries only bit k in its dest field, with source id and payload unchanged.
- R3: A cell with several dest bits set is handed out exactly once at each egress it names, and nowhere else.
- R4: The loop moves stage 0 to stage 1 to stage 3 to stage 2 and back to stage 0, one hop per clock. On an idle switch, a cell from ingress 0 raises out_valid[k] after 3, 4, 5 or 6 rising edges for k = 1, 3, 2, 0 respectively. The edge that captures the cell counts as the first.
- R5: When a stage holds a cell with its own port's bit set and that egress queue has room, a copy is written to the queue and the bit is cleared in the same cycle.
- R6: When the egress queue is full, the bit stays set and the cell keeps circulating. It is delivered once room appears, so no copy is lost.
- R7: Each queue holds four cells. An ingress queue places its head on the loop only in a cycle when its port's stage has no pending bits after ejection. While the loop is full of undeliverable cells, no new cell enters.
- R8: A cell arriving at a full ingress queue is discarded and adds one to cnt_dropped. The four cells already queued are kept.
- R9: A cell whose dest mask is zero is discarded when it reaches the head of the queue. It adds one to cnt_dropped and is never handed out.
- R10: cnt_accepted counts cells written into ingress queues. cnt_delivered counts egress handshakes (out_valid and out_ready both high).
- R11: out_valid[k] is high while egress queue k is non-empty. While it is high and out_ready[k] is low, out_cell[k] holds steady.
- R12: A synchronous active-high reset empties all queues and loop stages and clears all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Per-ingress cell strobe |
| in_cell | input | 4x16 | Per-ingress cell |
| out_valid | output | 4 | Egress queue non-empty |
| out_ready | input | 4 | Egress consumer takes the head cell |
| out_cell | output | 4x16 | Egress head cell |
| cnt_accepted | output | 16 | Cells taken into ingress queues |
| cnt_delivered | output | 16 | Copies handed out at egress |
| cnt_dropped | output | 16 | Cells discarded (full ingress or empty mask) |

## Verification
The assertions check properties that hold on every clock. A cell left with pending bits arrives intact at the next stage in loop order. A served bit is gone one hop later, while a blocked bit survives. No queue is pushed when full or popped when empty. Egress heads carry a one-hot dest and hold steady under back-pressure. Only the bench scenarios can show end-to-end results: each multicast copy reaching exactly its named egress ports, the hop-count latencies that expose the loop order, recovery after the egress queue drains, and the exact drop and delivery totals under overload.

// File: rtl/ring_sw_pkg.sv
package ring_sw_pkg;

    localparam int NPORTS = 4;
    localparam int DEST_W = NPORTS;
    localparam int SRC_W  = 4;
    localparam int DATA_W = 8;
    localparam int CELL_W = DEST_W + SRC_W + DATA_W;
    localparam int PCNT_W = $clog2(NPORTS) + 1;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [SRC_W-1:0]  src;
        logic [DATA_W-1:0] data;
    } cell_t;

    typedef struct packed {
        logic [DEST_W-1:0] pend;
        logic [SRC_W-1:0]  src;
        logic [DATA_W-1:0] data;
    } slot_t;

    function automatic int to_gray(int b);
        return b ^ (b >> 1);
    endfunction

    function automatic int from_gray(int g);
        int b;
        b = g;
        for (int sh = 1; sh < 32; sh = sh << 1) b = b ^ (b >> sh);
        return b;
    endfunction

    // loop order follows a Gray sequence: 0 -> 1 -> 3 -> 2 -> 0
    function automatic int ring_next(int s);
        return to_gray((from_gray(s) + 1) % NPORTS);
    endfunction

    function automatic int ring_prev(int s);
        return to_gray((from_gray(s) + NPORTS - 1) % NPORTS);
    endfunction

    function automatic logic [PCNT_W-1:0] ones(logic [NPORTS-1:0] v);
        logic [PCNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < NPORTS; i++) n = n + PCNT_W'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/cell_fifo.sv
module cell_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          push, pop;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign push  = wr_en && !full;
    assign pop   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);
    a_r11_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);
    a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

endmodule

// File: rtl/ring_node.sv
module ring_node
    import ring_sw_pkg::*;
#(
    parameter int PORT = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  slot_t cur,
    input  logic  ofull,
    input  logic  iempty,
    input  cell_t ihead,
    output logic  eject,
    output cell_t ecell,
    output logic  ipop,
    output logic  zdrop,
    output slot_t nxt
);
    localparam logic [DEST_W-1:0] OWN_BIT = DEST_W'(1) << PORT;

    logic [DEST_W-1:0] remain;
    logic              free;

    always_comb begin
        eject  = cur.pend[PORT] && !ofull;
        remain = eject ? (cur.pend & ~OWN_BIT) : cur.pend;
        free   = (remain == '0);
        ipop   = free && !iempty;
        zdrop  = ipop && (ihead.dest == '0);

        ecell.dest = OWN_BIT;
        ecell.src  = cur.src;
        ecell.data = cur.data;

        if (!free) begin
            nxt.pend = remain;
            nxt.src  = cur.src;
            nxt.data = cur.data;
        end else if (ipop && !zdrop) begin
            nxt.pend = ihead.dest;
            nxt.src  = ihead.src;
            nxt.data = ihead.data;
        end else begin
            nxt = '0;
        end
    end

    // R6: a blocked bit survives the hop
    a_r6_blocked_bit_kept: assert property (@(posedge clk) disable iff (rst)
        (cur.pend[PORT] && ofull) |-> (nxt.pend[PORT] && nxt.data == cur.data));
    // R7: a cell with other pending bits is never overwritten
    a_r7_no_inject_when_busy: assert property (@(posedge clk) disable iff (rst)
        ((cur.pend & ~OWN_BIT) != '0) |-> !ipop);

endmodule

// File: rtl/ring_switch.sv
module ring_switch
    import ring_sw_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NPORTS-1:0]              in_valid,
    input  logic [NPORTS-1:0][CELL_W-1:0]  in_cell,
    output logic [NPORTS-1:0]              out_valid,
    input  logic [NPORTS-1:0]              out_ready,
    output logic [NPORTS-1:0][CELL_W-1:0]  out_cell,
    output logic [CNT_W-1:0]               cnt_accepted,
    output logic [CNT_W-1:0]               cnt_delivered,
    output logic [CNT_W-1:0]               cnt_dropped
);
    slot_t ring_q [NPORTS];
    slot_t ring_d [NPORTS];
    slot_t nxt_s  [NPORTS];

    logic [NPORTS-1:0] ififo_full, ififo_empty, ipop, zdrop;
    logic [NPORTS-1:0] ofifo_full, ofifo_empty, eject, in_wr, out_rd;
    logic [NPORTS-1:0][CELL_W-1:0] ihead_raw;
    cell_t ecell  [NPORTS];

    assign in_wr     = in_valid & ~ififo_full;
    assign out_valid = ~ofifo_empty;
    assign out_rd    = out_valid & out_ready;

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        localparam int PREV = ring_prev(g);
        localparam int NEXT = ring_next(g);
        localparam logic [DEST_W-1:0] OWN_BIT = DEST_W'(1) << g;

        cell_fifo #(.W(CELL_W), .DEPTH(FIFO_DEPTH)) u_ingress (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (in_wr[g]),
            .wr_data (in_cell[g]),
            .rd_en   (ipop[g]),
            .rd_data (ihead_raw[g]),
            .full    (ififo_full[g]),
            .empty   (ififo_empty[g])
        );

        ring_node #(.PORT(g)) u_node (
            .clk    (clk),
            .rst    (rst),
            .cur    (ring_q[g]),
            .ofull  (ofifo_full[g]),
            .iempty (ififo_empty[g]),
            .ihead  (cell_t'(ihead_raw[g])),
            .eject  (eject[g]),
            .ecell  (ecell[g]),
            .ipop   (ipop[g]),
            .zdrop  (zdrop[g]),
            .nxt    (nxt_s[g])
        );

        cell_fifo #(.W(CELL_W), .DEPTH(FIFO_DEPTH)) u_egress (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (eject[g]),
            .wr_data (ecell[g]),
            .rd_en   (out_rd[g]),
            .rd_data (out_cell[g]),
            .full    (ofifo_full[g]),
            .empty   (ofifo_empty[g])
        );

        assign ring_d[g] = nxt_s[PREV];

        // R4: pending cell moves intact to the next stage in loop order
        a_r4_hop_order: assert property (@(posedge clk) disable iff (rst)
            ((ring_q[g].pend & ~OWN_BIT) != '0) |=>
                (ring_q[NEXT].src == $past(ring_q[g].src) &&
                 ring_q[NEXT].data == $past(ring_q[g].data)));
        // R5: a served bit is gone one hop later
        a_r5_bit_cleared: assert property (@(posedge clk) disable iff (rst)
            (ring_q[g].pend[g] && !ofifo_full[g] &&
             ((ring_q[g].pend & ~OWN_BIT) != '0)) |=> !ring_q[NEXT].pend[g]);
        // R2: egress head names only its own port
        a_r2_out_dest_onehot: assert property (@(posedge clk) disable iff (rst)
            out_valid[g] |-> (out_cell[g][CELL_W-1 -: DEST_W] == OWN_BIT));
        // R11: head held under back-pressure
        a_r11_hold_stalled: assert property (@(posedge clk) disable iff (rst)
            (out_valid[g] && !out_ready[g]) |=> (out_valid[g] && $stable(out_cell[g])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPORTS; i++) ring_q[i] <= '0;
        end else begin
            for (int i = 0; i < NPORTS; i++) ring_q[i] <= ring_d[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_accepted  <= '0;
            cnt_delivered <= '0;
            cnt_dropped   <= '0;
        end else begin
            cnt_accepted  <= cnt_accepted  + CNT_W'(ones(in_wr));
            cnt_delivered <= cnt_delivered + CNT_W'(ones(out_rd));
            cnt_dropped   <= cnt_dropped   + CNT_W'(ones(in_valid & ififo_full))
                                           + CNT_W'(ones(zdrop));
        end
    end

endmodule

// File: tb/ring_switch_tb.sv
`timescale 1ns/1ps
module ring_switch_tb_top;

    logic             clk = 1'b0;
    logic             rst;
    logic [3:0]       in_valid;
    logic [3:0][15:0] in_cell;
    logic [3:0]       out_valid;
    logic [3:0]       out_ready;
    logic [3:0][15:0] out_cell;
    logic [15:0]      cnt_accepted, cnt_delivered, cnt_dropped;

    int checks = 0;
    int fails  = 0;
    int exp_acc = 0, exp_copies = 0, exp_drop = 0;
    bit done = 0;
    logic [15:0] exp_q [4][$];

    always #4 clk = ~clk;

    ring_switch dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cell(in_cell),
        .out_valid(out_valid), .out_ready(out_ready), .out_cell(out_cell),
        .cnt_accepted(cnt_accepted), .cnt_delivered(cnt_delivered),
        .cnt_dropped(cnt_dropped)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // R1/R2/R3: expected copies, one per named egress, dest rewritten one-hot
    task automatic expect_cell(int p, logic [3:0] dest, logic [7:0] data);
        for (int k = 0; k < 4; k++) begin
            if (dest[k]) begin
                exp_q[k].push_back({4'(1 << k), 4'(p), data});
                exp_copies++;
            end
        end
    endtask

    task automatic send(int p, logic [3:0] dest, logic [7:0] data);
        in_valid[p] = 1'b1;
        in_cell[p]  = {dest, 4'(p), data};
        step();
        in_valid[p] = 1'b0;
    endtask

    // scoreboard monitor: unordered match per egress
    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < 4; k++) begin
                if (out_valid[k] && out_ready[k]) begin
                    bit found;
                    found = 0;
                    for (int j = 0; j < exp_q[k].size(); j++) begin
                        if (!found && exp_q[k][j] == out_cell[k]) begin
                            exp_q[k].delete(j);
                            found = 1;
                        end
                    end
                    checks++;
                    if (!found) begin
                        fails++;
                        $display("FAIL R3 egress %0d actual=%h expected=%h", k, out_cell[k],
                                 exp_q[k].size() > 0 ? exp_q[k][0] : 16'hxxxx);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = '0;
        in_cell = '0;
        out_ready = 4'hF;
        wait_cycles(3);
        rst = 1'b0;
        step();

        // R12: reset state
        chk("R12 out_valid", int'(out_valid), 0);
        chk("R12 cnt_accepted", int'(cnt_accepted), 0);
        chk("R12 cnt_delivered", int'(cnt_delivered), 0);
        chk("R12 cnt_dropped", int'(cnt_dropped), 0);

        // R4: latency from ingress 0 reveals loop order 0->1->3->2->0
        begin
            int lat_exp [4] = '{6, 3, 5, 4};
            for (int k = 0; k < 4; k++) begin
                int n;
                expect_cell(0, 4'(1 << k), 8'h10 + 8'(k));
                exp_acc++;
                send(0, 4'(1 << k), 8'h10 + 8'(k));
                n = 1;
                while (!out_valid[k] && n < 20) begin
                    step();
                    n++;
                end
                chk($sformatf("R4 latency to egress %0d", k), n, lat_exp[k]);
                wait_cycles(8);
            end
        end

        // R3: multicast to all four
        expect_cell(1, 4'hF, 8'h5A); exp_acc++;
        send(1, 4'hF, 8'h5A);
        wait_cycles(10);
        // R3: self-addressed cell needs a full lap
        expect_cell(3, 4'h8, 8'h33); exp_acc++;
        send(3, 4'h8, 8'h33);
        wait_cycles(10);
        for (int k = 0; k < 4; k++) chk("R3 queue drained", exp_q[k].size(), 0);

        // R1/R2: mixed multicast traffic on all ingress ports at once
        for (int r = 0; r < 5; r++) begin
            for (int p = 0; p < 4; p++) begin
                logic [3:0] d;
                d = 4'(((p + r * 3 + 1) % 15) + 1);
                expect_cell(p, d, 8'(r * 16 + p));
                exp_acc++;
                in_valid[p] = 1'b1;
                in_cell[p]  = {d, 4'(p), 8'(r * 16 + p)};
            end
            step();
            in_valid = '0;
            wait_cycles(7);
        end
        wait_cycles(10);
        for (int k = 0; k < 4; k++) chk("R1 mixed traffic drained", exp_q[k].size(), 0);
        chk("R1 no drops in light load", int'(cnt_dropped), 0);

        // R9: empty mask is discarded and counted
        exp_acc++; exp_drop++;
        send(2, 4'h0, 8'hEE);
        wait_cycles(10);
        chk("R9 cnt_dropped", int'(cnt_dropped), exp_drop);
        chk("R9 nothing out", int'(out_valid), 0);

        // R6/R11: back-pressure on egress 0
        out_ready = 4'b1110;
        for (int j = 0; j < 4; j++) begin
            expect_cell(0, 4'h1, 8'hA0 + 8'(j)); exp_acc++;
            send(0, 4'h1, 8'hA0 + 8'(j));
        end
        wait_cycles(15);
        chk("R11 out_valid held", int'(out_valid[0]), 1);
        begin
            logic [15:0] held;
            int dlv;
            held = out_cell[0];
            dlv = int'(cnt_delivered);
            wait_cycles(5);
            chk("R11 out_cell stable", int'(out_cell[0]), int'(held));
            chk("R11 no handshake while stalled", int'(cnt_delivered), dlv);
        end

        // R7: four undeliverable cells fill the loop
        for (int p = 0; p < 4; p++) begin
            expect_cell(p, 4'h1, 8'hB0 + 8'(p)); exp_acc++;
            in_valid[p] = 1'b1;
            in_cell[p]  = {4'h1, 4'(p), 8'hB0 + 8'(p)};
        end
        step();
        in_valid = '0;
        wait_cycles(8);

        // R8: ingress 2 overflows: four kept, two discarded
        begin
            int d0, a0;
            d0 = int'(cnt_dropped);
            a0 = int'(cnt_accepted);
            for (int j = 0; j < 6; j++) begin
                if (j < 4) begin
                    expect_cell(2, 4'h4, 8'hC0 + 8'(j)); exp_acc++;
                end else begin
                    exp_drop++;
                end
                send(2, 4'h4, 8'hC0 + 8'(j));
            end
            wait_cycles(10);
            chk("R8 dropped delta", int'(cnt_dropped) - d0, 2);
            chk("R8 accepted delta", int'(cnt_accepted) - a0, 4);
            chk("R7 loop full, no entry", int'(out_valid[2]), 0);
        end

        // R6: release back-pressure, everything drains
        out_ready = 4'hF;
        wait_cycles(80);
        for (int k = 0; k < 4; k++) chk($sformatf("R6 egress %0d drained", k), exp_q[k].size(), 0);
        chk("R10 cnt_accepted", int'(cnt_accepted), exp_acc);
        chk("R10 cnt_delivered", int'(cnt_delivered), exp_copies);
        chk("R8 cnt_dropped total", int'(cnt_dropped), exp_drop);
        chk("R11 idle out_valid", int'(out_valid), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule